// File: doc/BRIEF.md
# Clock-Aware Reset Extension Controller

This block turns an asynchronous, active-low board reset into a clean internal reset for a chip whose interface clocks may arrive late. A free-running reference clock watches a set of monitored clocks. Each monitored clock toggles a flag in its own domain. The reference domain samples that flag through a two-flop synchroniser and counts the changes. A clock is accepted as running after a set number of consecutive toggles. It is declared lost after a set number of reference cycles pass without a toggle.

The internal reset is asserted at once, with no clock edge needed, while the board reset is low. It is released on a reference clock edge, and only after every monitored clock has run for a long stretch interval. A later milestone, the register-ready flag, tells the rest of the chip that configuration accesses are now safe.

If a monitored clock is missing when the board reset lifts, the internal reset stays held. The stretch starts only once that clock is seen toggling. If any monitored clock stops later, the whole sequence is re-armed. Both delays are parameters counted in reference cycles, so the real values of hundreds of microseconds can be shortened for simulation.

Top module: `rstx_top`

## Requirements
- R1: While `ext_rst_n` is low, `int_rst` is 1 and `reg_ready` is 0. Both take these values as soon as `ext_rst_n` falls, before the next `ref_clk` edge.
- R2: `int_rst` stays high for exactly STRETCH_CYC reference cycles after all monitored clocks are detected as running, then falls just after a `ref_clk` rising edge. For clocks whose period is at most 7 reference cycles, with RUN_TOGGLES=4, the fall comes between STRETCH_CYC and STRETCH_CYC+45 reference cycles after the board reset is released.
- R3: `reg_ready` rises exactly READY_CYC-STRETCH_CYC reference cycles after `int_rst` falls.
- R4: `reg_ready` is never 1 while `int_rst` is 1.
- R5: If a monitored clock is not toggling when `ext_rst_n` rises, `int_rst` stays 1 and `reg_ready` stays 0 for as long as that clock is absent. Once the clock starts, `int_rst` falls between STRETCH_CYC and STRETCH_CYC+45 reference cycles after the start.
- R6: If a running monitored clock stops, `int_rst` is 1 and `reg_ready` is 0 within LOSS_CYC+12 reference cycles. When the clock returns, the R2 and R3 timing repeats.
- R7: A monitored clock that gives fewer than RUN_TOGGLES toggles does not count as running, and the internal reset stays held.
- R8: A board reset pulse during the stretch restarts the stretch from zero. After the second release, the R2 window applies again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock that drives all control logic |
| ext_rst_n | input | 1 | Asynchronous board reset, active low |
| mon_clk | input | NUM_CLKS | Monitored clocks, one bit per clock |
| int_rst | output | 1 | Internal reset, active high; asserts asynchronously, releases on `ref_clk` |
| reg_ready | output | 1 | High once register accesses are permitted |

## Verification
The hardest situations to reach from the ports are a clock that starts only after the board reset is released, and a clock that gives only a couple of edges before going quiet. The bench drives each monitored clock from its own generator with a separate enable. It holds one generator off through the reset release, and it can also inject single hand-made pulses on that line. Each scenario varies the clock periods and the start delay. The bench then measures, in reference cycles, the distance from the release or clock start to the fall of `int_rst`, and from that fall to the rise of `reg_ready`.

// File: rtl/rstx_pkg.sv
package rstx_pkg;

    // Phases of the reset stretch sequence
    typedef enum logic [1:0] {
        PH_HOLD    = 2'd0,  // waiting for all clocks to be seen running
        PH_STRETCH = 2'd1,  // clocks good, internal reset still held
        PH_SETTLE  = 2'd2,  // internal reset released, registers not yet open
        PH_READY   = 2'd3   // register access permitted
    } phase_e;

    function automatic logic phase_holds_reset(phase_e ph);
        return (ph == PH_HOLD) || (ph == PH_STRETCH);
    endfunction

    function automatic int cnt_width(int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/rstx_sync.sv
module rstx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst
);
    logic [STAGES-1:0] chain_q;

    // Assert at once, release after STAGES clean edges
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '1;
        else         chain_q <= {chain_q[STAGES-2:0], 1'b0};
    end

    assign rst = chain_q[STAGES-1];

    initial begin
        if (STAGES < 2) $error("rstx_sync needs at least two stages");
    end
endmodule

// File: rtl/rstx_clk_mon.sv
module rstx_clk_mon #(
    parameter int DIV_LOG2    = 0,
    parameter int RUN_TOGGLES = 4,
    parameter int LOSS_CYC    = 10
) (
    input  logic mon_clk,
    input  logic arst_n,
    input  logic ref_clk,
    input  logic ref_rst,
    output logic running
);
    import rstx_pkg::*;

    localparam int RW = cnt_width(RUN_TOGGLES);
    localparam int MW = cnt_width(LOSS_CYC);

    logic flag_q;

    // Activity flag in the monitored domain, optionally slowed by a divider
    generate
        if (DIV_LOG2 == 0) begin : g_direct
            always_ff @(posedge mon_clk or negedge arst_n) begin
                if (!arst_n) flag_q <= 1'b0;
                else         flag_q <= ~flag_q;
            end
        end else begin : g_div
            logic [DIV_LOG2-1:0] div_q;
            always_ff @(posedge mon_clk or negedge arst_n) begin
                if (!arst_n) begin
                    div_q  <= '0;
                    flag_q <= 1'b0;
                end else begin
                    div_q <= div_q + DIV_LOG2'(1);
                    if (&div_q) flag_q <= ~flag_q;
                end
            end
        end
    endgenerate

    // Reference domain: two sync flops plus one history flop
    logic [2:0]    sync_q;
    logic [RW-1:0] run_cnt_q;
    logic [MW-1:0] miss_cnt_q;
    logic          edge_seen;

    assign edge_seen = sync_q[2] ^ sync_q[1];

    always_ff @(posedge ref_clk or posedge ref_rst) begin
        if (ref_rst) begin
            sync_q     <= '0;
            run_cnt_q  <= '0;
            miss_cnt_q <= '0;
        end else begin
            sync_q <= {sync_q[1:0], flag_q};
            if (edge_seen) begin
                miss_cnt_q <= '0;
                if (run_cnt_q != RW'(RUN_TOGGLES)) run_cnt_q <= run_cnt_q + RW'(1);
            end else if (miss_cnt_q == MW'(LOSS_CYC - 1)) begin
                miss_cnt_q <= '0;
                run_cnt_q  <= '0;
            end else begin
                miss_cnt_q <= miss_cnt_q + MW'(1);
            end
        end
    end

    assign running = (run_cnt_q == RW'(RUN_TOGGLES));

    // A silent window of LOSS_CYC cycles drops the running state
    p_loss_clears_r6: assert property (@(posedge ref_clk) disable iff (ref_rst)
        (!edge_seen && miss_cnt_q == MW'(LOSS_CYC - 1)) |=> !running);

    // Running can only be reached through an observed toggle
    p_run_needs_toggle_r7: assert property (@(posedge ref_clk) disable iff (ref_rst)
        $rose(running) |-> $past(edge_seen));
endmodule

// File: rtl/rstx_stretch.sv
module rstx_stretch #(
    parameter int STRETCH_CYC = 22000,
    parameter int READY_CYC   = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic all_running,
    output logic int_rst,
    output logic ready
);
    import rstx_pkg::*;

    localparam int CW = cnt_width(READY_CYC);

    phase_e        phase_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            phase_q <= PH_HOLD;
            cnt_q   <= '0;
        end else if (!all_running) begin
            phase_q <= PH_HOLD;
            cnt_q   <= '0;
        end else begin
            case (phase_q)
                PH_HOLD: begin
                    phase_q <= PH_STRETCH;
                    cnt_q   <= '0;
                end
                PH_STRETCH: begin
                    cnt_q <= cnt_q + CW'(1);
                    if (cnt_q == CW'(STRETCH_CYC - 1)) phase_q <= PH_SETTLE;
                end
                PH_SETTLE: begin
                    if (cnt_q == CW'(READY_CYC - 1)) phase_q <= PH_READY;
                    else                             cnt_q   <= cnt_q + CW'(1);
                end
                default: ;
            endcase
        end
    end

    assign int_rst = rst | phase_holds_reset(phase_q);
    assign ready   = !rst && (phase_q == PH_READY);

    initial begin
        if (READY_CYC <= STRETCH_CYC) $error("READY_CYC must exceed STRETCH_CYC");
    end

    // Release happens only after a full stretch count
    p_release_after_stretch_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(int_rst) |-> ($past(phase_q) == PH_STRETCH && $past(cnt_q) == CW'(STRETCH_CYC - 1)));

    p_stretch_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_STRETCH) |-> (cnt_q < CW'(STRETCH_CYC)));

    // Ready only comes after the reset was already released
    p_ready_after_release_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> !$past(int_rst));

    // Missing clocks keep the reset held
    p_hold_without_clocks_r5: assert property (@(posedge clk) disable iff (rst)
        !all_running |=> int_rst);
endmodule

// File: rtl/rstx_top.sv
module rstx_top #(
    parameter int NUM_CLKS    = 2,
    parameter int DIV_LOG2    = 0,
    parameter int RUN_TOGGLES = 4,
    parameter int LOSS_CYC    = 10,
    parameter int STRETCH_CYC = 22000,
    parameter int READY_CYC   = 50000
) (
    input  logic                ref_clk,
    input  logic                ext_rst_n,
    input  logic [NUM_CLKS-1:0] mon_clk,
    output logic                int_rst,
    output logic                reg_ready
);
    logic                ref_rst;
    logic [NUM_CLKS-1:0] run_vec;
    logic                all_running;

    rstx_sync #(.STAGES(2)) u_sync (
        .clk    (ref_clk),
        .arst_n (ext_rst_n),
        .rst    (ref_rst)
    );

    generate
        for (genvar i = 0; i < NUM_CLKS; i++) begin : g_mon
            rstx_clk_mon #(
                .DIV_LOG2    (DIV_LOG2),
                .RUN_TOGGLES (RUN_TOGGLES),
                .LOSS_CYC    (LOSS_CYC)
            ) u_mon (
                .mon_clk (mon_clk[i]),
                .arst_n  (ext_rst_n),
                .ref_clk (ref_clk),
                .ref_rst (ref_rst),
                .running (run_vec[i])
            );
        end
    endgenerate

    assign all_running = &run_vec;

    rstx_stretch #(
        .STRETCH_CYC (STRETCH_CYC),
        .READY_CYC   (READY_CYC)
    ) u_stretch (
        .clk         (ref_clk),
        .rst         (ref_rst),
        .all_running (all_running),
        .int_rst     (int_rst),
        .ready       (reg_ready)
    );

    // Losing any clock withdraws the ready flag on the next edge
    p_ready_drops_on_loss_r6: assert property (@(posedge ref_clk) disable iff (ref_rst)
        !all_running |=> !reg_ready);
endmodule

// File: tb/rstx_top_tb.sv
`timescale 1ns/1ps
module rstx_top_tb;
    localparam int CLK_NS   = 10;
    localparam int STRETCH  = 40;
    localparam int READY    = 100;
    localparam int RUN_TOG  = 4;
    localparam int LOSS     = 10;
    localparam int SLACK    = 45;
    localparam int N_SCEN   = 5;
    // period of clock 0 (ns), period of clock 1 (ns), late start of clock 1 (ref cycles)
    localparam int SCEN [0:N_SCEN-1][0:2] = '{
        '{30, 50, 0},
        '{50, 30, 0},
        '{70, 20, 0},
        '{30, 50, 200},
        '{40, 60, 120}
    };

    logic ref_clk = 1'b0;
    logic ext_rst_n = 1'b0;
    logic gclk0 = 1'b0, gclk1 = 1'b0, man1 = 1'b0;
    logic en0 = 1'b0, en1 = 1'b0;
    int   half0 = 15, half1 = 25;
    logic int_rst, reg_ready;
    int   checks = 0, fails = 0;
    logic overlap_seen = 1'b0;

    always #(CLK_NS/2) ref_clk = ~ref_clk;

    initial begin
        #3;
        forever begin
            if (en0) begin #(half0); gclk0 = ~gclk0; end
            else begin gclk0 = 1'b0; #5; end
        end
    end
    initial begin
        #3;
        forever begin
            if (en1) begin #(half1); gclk1 = ~gclk1; end
            else begin gclk1 = 1'b0; #5; end
        end
    end

    rstx_top #(
        .NUM_CLKS(2), .DIV_LOG2(0), .RUN_TOGGLES(RUN_TOG),
        .LOSS_CYC(LOSS), .STRETCH_CYC(STRETCH), .READY_CYC(READY)
    ) u_dut (
        .ref_clk   (ref_clk),
        .ext_rst_n (ext_rst_n),
        .mon_clk   ({gclk1 | man1, gclk0}),
        .int_rst   (int_rst),
        .reg_ready (reg_ready)
    );

    // R4: continuous watch for ready while reset is held
    always @(negedge ref_clk) if (int_rst && reg_ready) overlap_seen = 1'b1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge ref_clk);
    endtask

    task automatic measure(output int t1, output int t2);
        t1 = 0;
        while (int_rst && t1 < 600) begin @(negedge ref_clk); t1++; end
        t2 = 0;
        while (!reg_ready && t2 < 600) begin @(negedge ref_clk); t2++; end
    endtask

    task automatic check_seq(input string req);
        int t1, t2;
        measure(t1, t2);
        check(t1 >= STRETCH && t1 <= STRETCH + SLACK, {req, " release window"}, t1, STRETCH);
        check(t2 == READY - STRETCH, "R3 ready gap", t2, READY - STRETCH);
    endtask

    initial begin
        #(CLK_NS * 100000);
        checks++; fails++;
        $display("FAIL watchdog: run hung, actual 0 expected 1");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        wait_cyc(3);
        check(int_rst == 1'b1, "R1 int_rst in reset", int_rst, 1);
        check(reg_ready == 1'b0, "R1 ready in reset", reg_ready, 0);

        // R2/R3/R5: scenario table
        for (int s = 0; s < N_SCEN; s++) begin
            ext_rst_n = 1'b0;
            half0 = SCEN[s][0] / 2;
            half1 = SCEN[s][1] / 2;
            en0 = 1'b1;
            en1 = (SCEN[s][2] == 0);
            wait_cyc(5);
            ext_rst_n = 1'b1;
            if (SCEN[s][2] != 0) begin
                wait_cyc(SCEN[s][2]);
                check(int_rst == 1'b1 && reg_ready == 1'b0, "R5 held while clock absent",
                      int_rst, 1);
                en1 = 1'b1;
                check_seq("R5");
            end else begin
                check_seq("R2");
            end
        end

        // R1: asynchronous assertion from the ready state
        #2; ext_rst_n = 1'b0;
        #1;
        check(int_rst == 1'b1, "R1 async int_rst", int_rst, 1);
        check(reg_ready == 1'b0, "R1 async ready", reg_ready, 0);
        @(negedge ref_clk);

        // R8: reset pulse during the stretch
        half0 = 15; half1 = 25; en0 = 1'b1; en1 = 1'b1;
        wait_cyc(3);
        ext_rst_n = 1'b1;
        wait_cyc(30);
        check(int_rst == 1'b1, "R8 still stretching", int_rst, 1);
        ext_rst_n = 1'b0;
        wait_cyc(3);
        ext_rst_n = 1'b1;
        check_seq("R8");

        // R6: clock loss after ready, then recovery
        en0 = 1'b0;
        wait_cyc(LOSS + 12);
        check(int_rst == 1'b1, "R6 reset re-asserted on loss", int_rst, 1);
        check(reg_ready == 1'b0, "R6 ready dropped on loss", reg_ready, 0);
        en0 = 1'b1;
        check_seq("R6");

        // R7: too few pulses on a late clock
        ext_rst_n = 1'b0;
        en1 = 1'b0;
        wait_cyc(4);
        ext_rst_n = 1'b1;
        wait_cyc(20);
        for (int p = 0; p < RUN_TOG - 2; p++) begin
            #2; man1 = 1'b1; #15; man1 = 1'b0;
            @(negedge ref_clk);
        end
        wait_cyc(100);
        check(int_rst == 1'b1, "R7 reset held after few pulses", int_rst, 1);
        check(reg_ready == 1'b0, "R7 ready low after few pulses", reg_ready, 0);
        en1 = 1'b1;
        check_seq("R7");

        check(!overlap_seen, "R4 ready never with reset", overlap_seen, 0);
        summary();
        $finish;
    end
endmodule